// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Interrupt Detection

This block is a general-purpose I/O peripheral for sixteen pads. Software reaches it through a plain 32-bit register port with a write strobe, a read strobe and a 3-bit word index. Through that port it sets the value each pad drives, chooses per pad whether the pad drives or listens, and reads back the synchronised pad levels. Read data is registered and appears one clock after the read strobe.

Every line has its own interrupt detector. A 3-bit style code for each line selects one of five conditions: a high level, a low level, a rising edge, a falling edge, or any transition. Detected events collect in a sticky pending register, and software clears bits in it by writing ones. Lines 0 to 12 each drive an active-high interrupt output that follows their pending bit. Lines 13 to 15 record events but have no interrupt output.

The design has no states or transitions to name. Its behaviour is the pipeline of pad synchroniser, detector and pending register, and the register file around it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the output-data register is 0, the direction register is 0x0000FFFF (all lines are inputs, `pad_drive` = 0), both style registers are 0, the pending register is 0, and `irq` is 0.
- R2: Word indices decode as follows: 0 = output data, 1 = direction, 2 = input level (read only), 3 = pending status, 4 = styles of lines 0–7, 5 = styles of lines 8–15. Indices 6 and 7 read as 0, and writes to them have no effect. `rdata` takes the addressed value one clock after a cycle with `rd_en` high and holds it otherwise.
- R3: A direction bit of 1 makes the line an input (`pad_drive[n]` = 0). A direction bit of 0 sets `pad_drive[n]` = 1. `pad_out` always equals the output-data register.
- R4: The input register shows a pad change that lies two clock edges back. A read issued at the first edge after the change still returns the old value. The output-data, direction and input registers read 0 in bits 31:16, and no register reads nonzero in bits 31:24.
- R5: Line n (n = 0..7) takes its style from bits [3n+2:3n] of word 4. Line n+8 takes its style from the same bits of word 5. Each style register holds 24 bits.
- R6: Style 0 (high level) and style 1 (low level) set the pending bit on every clock in which the synchronised level is active. A clear written while the level is still active does not hold.
- R7: Style 2 sets the pending bit on a 0-to-1 change of the synchronised input, and style 3 sets it on a 1-to-0 change. For a pad change before clock edge k, the pending bit is set at edge k+2 and `irq` is visible after it.
- R8: Style 4 sets the pending bit on either change of the synchronised input.
- R9: Style codes 5, 6 and 7 never set a pending bit.
- R10: Writing word 3 clears each pending bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. A detection in the same clock wins over the clear. Without such a write, pending bits never fall.
- R11: `irq[n]` equals pending bit n for n = 0..12. Pending bits 13–15 are recorded and readable but drive no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Raw pad levels |
| pad_out | output | 16 | Value each pad drives when enabled |
| pad_drive | output | 16 | Per-pad driver enable, 1 = drive |
| irq | output | 13 | Active-high interrupts of lines 0–12 |

## Verification
The bench builds the block with its default parameters: sixteen lines, thirteen interrupt outputs and 3-bit style fields. These defaults give full reach over both halves of the style packing, the reserved codes and the three lines that have a pending bit but no output. A behavioural reference model runs in parallel and is compared every clock on `irq`, `pad_out` and `pad_drive`, and on every read. Directed checks pin down the synchroniser delay and the edge-to-interrupt latency. A random phase then covers random pads, random styles and clears.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // per-line detection style codes; 5..7 are reserved
    typedef enum logic [2:0] {
        STY_LVL_HI = 3'd0,
        STY_LVL_LO = 3'd1,
        STY_RISE   = 3'd2,
        STY_FALL   = 3'd3,
        STY_ANY    = 3'd4
    } style_e;

    // word indices of the register file
    localparam logic [2:0] REG_OUT  = 3'd0;
    localparam logic [2:0] REG_DIR  = 3'd1;
    localparam logic [2:0] REG_IN   = 3'd2;
    localparam logic [2:0] REG_STAT = 3'd3;
    localparam logic [2:0] REG_STYA = 3'd4;
    localparam logic [2:0] REG_STYB = 3'd5;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    logic [W-1:0] meta_q;

    // two-flop synchroniser followed by a one-cycle history stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= raw;
            cur    <= meta_q;
            prev   <= cur;
        end
    end

endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] style,
    input  logic       cur,
    input  logic       prev,
    output logic       evt
);

    always_comb begin
        unique case (style)
            STY_LVL_HI: evt = cur;
            STY_LVL_LO: evt = ~cur;
            STY_RISE:   evt = cur & ~prev;
            STY_FALL:   evt = ~cur & prev;
            STY_ANY:    evt = cur ^ prev;
            default:    evt = 1'b0;
        endcase
    end

    // R9: reserved codes stay silent
    p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (style > 3'd4) |-> !evt);

    // R7: edge styles see nothing while the input is steady
    p_edge_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((style == STY_RISE || style == STY_FALL || style == STY_ANY) && (cur == prev)) |-> !evt);

    // R6: an active level always produces an event
    p_level_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((style == STY_LVL_HI && cur) || (style == STY_LVL_LO && !cur)) |-> evt);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int NIRQ   = 13,
    parameter int DW     = 32,
    parameter int AW     = 3,
    parameter int STY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_drive,
    output logic [NIRQ-1:0]   irq
);

    localparam int LPR      = NLINES / 2;
    localparam int STY_BITS = LPR * STY_W;

    logic [NLINES-1:0]   out_q, dir_q, status_q;
    logic [STY_BITS-1:0] sty_a_q, sty_b_q;
    logic [NLINES-1:0]   in_cur, in_prev, evt;
    logic [NLINES-1:0]   clr_mask;
    logic [DW-1:0]       rd_mux;
    logic                st_wr;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DW-1:STY_BITS];

    gpio_in_sync #(.W(NLINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pad_in),
        .cur  (in_cur),
        .prev (in_prev)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [STY_W-1:0] sty;
        if (i < LPR) begin : g_lo
            assign sty = sty_a_q[STY_W*i +: STY_W];
        end else begin : g_hi
            assign sty = sty_b_q[STY_W*(i-LPR) +: STY_W];
        end
        gpio_line_detect u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .style(sty),
            .cur  (in_cur[i]),
            .prev (in_prev[i]),
            .evt  (evt[i])
        );
    end

    assign st_wr    = wr_en && (addr == REG_STAT);
    assign clr_mask = st_wr ? wdata[NLINES-1:0] : '0;

    // register file writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '1;
            sty_a_q <= '0;
            sty_b_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                REG_OUT:  out_q   <= wdata[NLINES-1:0];
                REG_DIR:  dir_q   <= wdata[NLINES-1:0];
                REG_STYA: sty_a_q <= wdata[STY_BITS-1:0];
                REG_STYB: sty_b_q <= wdata[STY_BITS-1:0];
                default:  ;
            endcase
        end
    end

    // sticky pending bits: detection wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | evt;
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            REG_OUT:  rd_mux[NLINES-1:0]   = out_q;
            REG_DIR:  rd_mux[NLINES-1:0]   = dir_q;
            REG_IN:   rd_mux[NLINES-1:0]   = in_cur;
            REG_STAT: rd_mux[NLINES-1:0]   = status_q;
            REG_STYA: rd_mux[STY_BITS-1:0] = sty_a_q;
            REG_STYB: rd_mux[STY_BITS-1:0] = sty_b_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign pad_out   = out_q;
    assign pad_drive = ~dir_q;
    assign irq       = status_q[NIRQ-1:0];

    // R10: a written one clears its bit unless an event arrives together
    p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((status_q & $past(wdata[NLINES-1:0] & ~evt)) == '0));

    // R10: without a status write, pending bits never fall
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R4: no register carries data above bit 23
    p_rdata_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:STY_BITS] == '0);

endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_drive;
    logic [12:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_drive(pad_drive), .irq(irq)
    );

    // behavioural reference model
    logic [15:0] m_out, m_oe, m_s1, m_s2, m_prev, m_status;
    logic [23:0] m_st0, m_st1;
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_out};
            3'd1: return {16'h0, m_oe};
            3'd2: return {16'h0, m_s2};
            3'd3: return {16'h0, m_status};
            3'd4: return {8'h0, m_st0};
            3'd5: return {8'h0, m_st1};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 0; m_oe = 16'hFFFF; m_s1 = 0; m_s2 = 0; m_prev = 0;
            m_status = 0; m_st0 = 0; m_st1 = 0; m_rdata = 0;
        end else begin
            logic [15:0] ev;
            logic [15:0] clr;
            for (int i = 0; i < 16; i++) begin
                int st;
                st = (i < 8) ? int'(m_st0[3*i +: 3]) : int'(m_st1[3*(i-8) +: 3]);
                case (st)
                    0: ev[i] = m_s2[i];
                    1: ev[i] = !m_s2[i];
                    2: ev[i] = m_s2[i] && !m_prev[i];
                    3: ev[i] = !m_s2[i] && m_prev[i];
                    4: ev[i] = m_s2[i] != m_prev[i];
                    default: ev[i] = 1'b0;
                endcase
            end
            clr = (wr_en && addr == 3'd3) ? wdata[15:0] : 16'h0;
            if (rd_en) m_rdata = m_read(addr);
            m_status = (m_status & ~clr) | ev;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
            if (wr_en) begin
                case (addr)
                    3'd0: m_out = wdata[15:0];
                    3'd1: m_oe  = wdata[15:0];
                    3'd4: m_st0 = wdata[23:0];
                    3'd5: m_st1 = wdata[23:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            chk("R11 irq vs model", {19'h0, irq}, {19'h0, m_status[12:0]});
            chk("R3 pad_out vs model", {16'h0, pad_out}, {16'h0, m_out});
            chk("R3 pad_drive vs model", {16'h0, pad_drive}, {16'h0, ~m_oe});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
        chk(tag, rdata, m_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        idle(4);
        rst_n = 1'b1;
        live = 1'b1;
        idle(1);
        // R1 reset state
        rd(3'd0, "R1 out reset", v);  chk("R1 out reset value", v, 32'h0);
        rd(3'd1, "R1 dir reset", v);  chk("R1 dir reset value", v, 32'h0000FFFF);
        rd(3'd3, "R1 status reset", v); chk("R1 status reset value", v, 32'h0);
        rd(3'd4, "R1 styleA reset", v); chk("R1 styleA reset value", v, 32'h0);
        rd(3'd5, "R1 styleB reset", v); chk("R1 styleB reset value", v, 32'h0);
        chk("R1 drive reset", {16'h0, pad_drive}, 32'h0);
        chk("R1 irq reset", {19'h0, irq}, 32'h0);
        // R2 / R4 output data and upper bits
        wr(3'd0, 32'hFFFF_A5A5);
        rd(3'd0, "R4 out read", v); chk("R4 out upper zero", v, 32'h0000A5A5);
        chk("R3 pad_out value", {16'h0, pad_out}, 32'h0000A5A5);
        // R3 direction
        wr(3'd1, 32'hFFFF_00FF);
        rd(3'd1, "R4 dir read", v); chk("R4 dir upper zero", v, 32'h000000FF);
        chk("R3 drive from dir", {16'h0, pad_drive}, 32'h0000FF00);
        // R2 unused words
        wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd6, "R2 word6", v); chk("R2 word6 zero", v, 32'h0);
        rd(3'd7, "R2 word7", v); chk("R2 word7 zero", v, 32'h0);
        // R5 style width
        wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd4, "R5 styleA width", v); chk("R5 styleA 24 bits", v, 32'h00FFFFFF);
        // R4 synchroniser delay
        pad_in = 16'h1234;
        idle(1);
        rd(3'd2, "R4 input early", v); chk("R4 input still old", v, 32'h0);
        rd(3'd2, "R4 input late", v);  chk("R4 input new", v, 32'h00001234);
        pad_in = 16'h0;
        idle(3);
        wr(3'd3, 32'h0000FFFF);
        // R5 packing: line0 rise, line1 low, line2 fall, line3 any, line4 res5, line5 res7
        wr(3'd4, 32'h0003D8CA);
        wr(3'd5, 32'h00490010);
        rd(3'd4, "R5 styleA", v); chk("R5 styleA value", v, 32'h0003D8CA);
        rd(3'd5, "R5 styleB", v); chk("R5 styleB value", v, 32'h00490010);
        // R7 edge latency on line 0
        pad_in[0] = 1'b1;
        idle(2);
        chk("R7 irq0 not yet", {31'h0, irq[0]}, 32'h0);
        idle(1);
        chk("R7 irq0 after latency", {31'h0, irq[0]}, 32'h1);
        rd(3'd3, "R6 status", v); chk("R6 low level line1 set", v & 32'h3, 32'h3);
        // R6 clear does not hold while level active
        wr(3'd3, 32'h2);
        idle(1);
        rd(3'd3, "R6 status relatch", v); chk("R6 bit1 sets again", v & 32'h2, 32'h2);
        pad_in[1] = 1'b1;
        idle(3);
        wr(3'd3, 32'h2);
        idle(2);
        rd(3'd3, "R6 status cleared", v); chk("R6 bit1 stays clear", v & 32'h2, 32'h0);
        // R7 falling on line 2
        pad_in[2] = 1'b1;
        idle(4);
        wr(3'd3, 32'hFFFF);
        idle(1);
        rd(3'd3, "R7 no fall yet", v); chk("R7 rise ignored by fall style", v & 32'h4, 32'h0);
        pad_in[2] = 1'b0;
        idle(4);
        rd(3'd3, "R7 fall", v); chk("R7 falling sets bit2", v & 32'h4, 32'h4);
        // R8 both edges on line 3
        wr(3'd3, 32'hFFFF);
        pad_in[3] = 1'b1;
        idle(4);
        rd(3'd3, "R8 rise", v); chk("R8 rise sets bit3", v & 32'h8, 32'h8);
        wr(3'd3, 32'h8);
        pad_in[3] = 1'b0;
        idle(4);
        rd(3'd3, "R8 fall", v); chk("R8 fall sets bit3", v & 32'h8, 32'h8);
        // R9 reserved codes
        wr(3'd3, 32'hFFFF);
        pad_in[5:4] = 2'b11;
        idle(4);
        pad_in[5:4] = 2'b00;
        idle(4);
        rd(3'd3, "R9 reserved", v); chk("R9 bits5:4 silent", v & 32'h30, 32'h0);
        // R11 lines 13-15 and line 9 (packed in word 5)
        wr(3'd3, 32'hFFFF);
        pad_in[15:13] = 3'b111;
        pad_in[9] = 1'b1;
        idle(4);
        rd(3'd3, "R11 status", v); chk("R11 status exact", v, 32'h0000E200);
        chk("R11 irq exact", {19'h0, irq}, 32'h00000200);
        // R10 write-one-to-clear
        wr(3'd3, 32'h0);
        rd(3'd3, "R10 zero write", v); chk("R10 zeros leave bits", v, 32'h0000E200);
        wr(3'd3, 32'h2000);
        rd(3'd3, "R10 one write", v); chk("R10 one clears bit13", v, 32'h0000C200);
        // random phase: model comparison every clock
        for (int k = 0; k < 600; k++) begin
            if (k % 150 == 0) begin
                wr(3'd4, $urandom & 32'h00FFFFFF);
                wr(3'd5, $urandom & 32'h00FFFFFF);
            end
            pad_in = 16'($urandom);
            if (k % 7 == 3) wr(3'd3, $urandom);
            else if (k % 11 == 5) rd(3'd3, "R10 random status", v);
            else if (k % 13 == 2) rd(3'd2, "R4 random input", v);
            else idle(1);
        end
        idle(2);
        finish_run();
    end

endmodule